// File: doc/BRIEF.md
# Two-Rank Crosspoint Configuration Register

This block holds the routing configuration for a 16-output switch matrix. Every output has one entry, made of a 4-bit code that picks the source input and an enable bit. Host writes do not reach the matrix directly. They land first in a staging rank. The driving rank feeds the matrix, and it takes a copy of the staging rank only while the active-low update input is held low. Software can therefore stage new settings for many outputs and then switch them all in the same cycle.

A write is triggered by the falling edge of an active-low write strobe. The write strobe, the update input and the clear input each pass through a multi-flop synchroniser clocked by the system clock. Chip select, the mode select and the serial-clock level are sampled as quasi-static qualifiers. With chip select low and the serial clock high, the mode select picks one of two write forms. When it is high, only the addressed entry is written. When it is low, every staging entry receives the same data word.

The active-low clear input turns off every enable in the driving rank, and it wins over update. It leaves the staging rank untouched. The staging rank has no reset and holds unknown contents at power-up, so every entry must be written before the first update.

Top module: `xbr_route_cfg`

## Requirements
- R1: While `rst_n` is low and after it is released, `route_en` is all zero and `route_sel` is all zero, until the first update.
- R2: A single-entry write occurs on a falling edge of `wr_n` while `cs_n`=0, `par_sel`=1 and `sclk`=1. It stores `din` into staging entry `addr`: `din[3:0]` is the source select and `din[4]` is the enable. A stored enable of 0 makes the output disabled whatever its select bits hold. Output i occupies `route_sel[4i+3:4i]` and `route_en[i]`.
- R3: While `upd_n` is high, staging writes leave `route_sel` and `route_en` unchanged.
- R4: Driving `upd_n` low copies every staging entry to the outputs within 6 clock cycles. Writes staged earlier therefore appear together.
- R5: While `upd_n` stays low, a new write reaches the outputs within 10 clock cycles of the strobe's falling edge, with no new update edge.
- R6: A falling edge of `wr_n` while `cs_n`=0, `par_sel`=0 and `sclk`=1 loads the same `din` into all 16 staging entries.
- R7: A falling edge of `wr_n` has no effect while `cs_n`=1, or while `sclk`=0 in either mode.
- R8: While `clr_n` is low, all bits of `route_en` read 0 within 6 cycles. This holds even if `upd_n` is also low.
- R9: `clr_n` does not alter the staging rank. The next copy after clear is released restores the staged enables and selects.
- R10: Only the high-to-low transition of `wr_n` writes. Holding `wr_n` low while `addr` or `din` changes, and the rising edge of `wr_n`, store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cs_n | input | 1 | Active-low chip select |
| par_sel | input | 1 | 1 = single-entry write, 0 = broadcast write |
| sclk | input | 1 | Serial clock level; must be high for a write |
| wr_n | input | 1 | Active-low write strobe; falling edge writes |
| upd_n | input | 1 | Active-low update; copies staging to driving rank |
| clr_n | input | 1 | Active-low clear; disables all outputs |
| addr | input | 4 | Output number to write |
| din | input | 5 | Bit 4 enable, bits 3..0 source select |
| route_sel | output | 64 | Packed per-output source selects |
| route_en | output | 16 | Per-output enables |

## Verification
Directed sequences cover four cases. Staged single writes under a held-high update show that the driving rank is isolated from writes. A broadcast followed by an update shows that every entry was loaded. Writes with a qualifier wrong, and a strobe held low while the address moves, show that only a qualified falling edge writes. Clear pulses with update high, then with update low, separate the clear's priority from its not touching the staging rank. Seeded random mixes of writes, broadcasts, update toggles and clears then compare both output vectors against a reference model after every step.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

   typedef enum logic [1:0] {
      WM_IDLE = 2'd0,
      WM_ONE  = 2'd1,
      WM_ALL  = 2'd2
   } wmode_e;

   // Qualifier decode: a strobe edge counts only with chip selected and serial clock parked high
   function automatic wmode_e decode_mode(input logic cs_n, input logic par_sel, input logic sclk);
      wmode_e m;
      m = WM_IDLE;
      if (!cs_n && sclk) begin
         m = par_sel ? WM_ONE : WM_ALL;
      end
      return m;
   endfunction

endpackage

// File: rtl/xbr_sync.sv
module xbr_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("xbr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{RST_VAL}};
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/xbr_strobe_dec.sv
module xbr_strobe_dec
   import xbr_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_s,
   input  logic              cs_n,
   input  logic              par_sel,
   input  logic              sclk,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              wr_one,
   output logic              wr_all,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   logic   wr_prev;
   logic   fall;
   wmode_e mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev <= 1'b1;
      end else begin
         wr_prev <= wr_s;
      end
   end

   assign fall = wr_prev & ~wr_s;

   always_comb begin
      mode   = decode_mode(cs_n, par_sel, sclk);
      wr_one = fall && (mode == WM_ONE);
      wr_all = fall && (mode == WM_ALL);
   end

   assign wr_addr = addr;
   assign wr_data = din;

endmodule

// File: rtl/xbr_rank1.sv
module xbr_rank1 #(
   parameter int N_OUT  = 16,
   parameter int ADDR_W = 4,
   parameter int SEL_W  = 4
) (
   input  logic                   clk,
   input  logic                   wr_one,
   input  logic                   wr_all,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [SEL_W-1:0]       wr_sel,
   input  logic                   wr_en,
   output logic [N_OUT*SEL_W-1:0] r1_sel,
   output logic [N_OUT-1:0]       r1_en
);

   // Staging entries carry no reset: contents are undefined until written
   for (genvar i = 0; i < N_OUT; i++) begin : g_entry
      logic hit;
      assign hit = wr_all || (wr_one && (wr_addr == ADDR_W'(i)));

      always_ff @(posedge clk) begin
         if (hit) begin
            r1_sel[i*SEL_W +: SEL_W] <= wr_sel;
            r1_en[i]                 <= wr_en;
         end
      end
   end

endmodule

// File: rtl/xbr_rank2.sv
module xbr_rank2 #(
   parameter int N_OUT        = 16,
   parameter int SEL_W        = 4,
   parameter bit CLR_ZERO_SEL = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr_s,
   input  logic                   upd_s,
   input  logic [N_OUT*SEL_W-1:0] r1_sel,
   input  logic [N_OUT-1:0]       r1_en,
   output logic [N_OUT*SEL_W-1:0] route_sel,
   output logic [N_OUT-1:0]       route_en
);

   for (genvar i = 0; i < N_OUT; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            route_en[i] <= 1'b0;
         end else if (!clr_s) begin
            route_en[i] <= 1'b0;
         end else if (!upd_s) begin
            route_en[i] <= r1_en[i];
         end
      end

      if (CLR_ZERO_SEL) begin : g_clr_sel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               route_sel[i*SEL_W +: SEL_W] <= '0;
            end else if (!clr_s) begin
               route_sel[i*SEL_W +: SEL_W] <= '0;
            end else if (!upd_s) begin
               route_sel[i*SEL_W +: SEL_W] <= r1_sel[i*SEL_W +: SEL_W];
            end
         end
      end else begin : g_keep_sel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               route_sel[i*SEL_W +: SEL_W] <= '0;
            end else if (clr_s && !upd_s) begin
               route_sel[i*SEL_W +: SEL_W] <= r1_sel[i*SEL_W +: SEL_W];
            end
         end
      end
   end

endmodule

// File: rtl/xbr_route_cfg.sv
module xbr_route_cfg #(
   parameter int N_OUT        = 16,
   parameter int SEL_W        = 4,
   parameter int SYNC_STAGES  = 2,
   parameter bit CLR_ZERO_SEL = 1'b0,
   localparam int ADDR_W      = (N_OUT > 1) ? $clog2(N_OUT) : 1,
   localparam int DATA_W      = SEL_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   par_sel,
   input  logic                   sclk,
   input  logic                   wr_n,
   input  logic                   upd_n,
   input  logic                   clr_n,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      din,
   output logic [N_OUT*SEL_W-1:0] route_sel,
   output logic [N_OUT-1:0]       route_en
);

   if (N_OUT < 2) begin : g_bad_nout
      $error("xbr_route_cfg: N_OUT must be at least 2");
   end
   if (SEL_W < 1) begin : g_bad_sel
      $error("xbr_route_cfg: SEL_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xbr_route_cfg: SYNC_STAGES must be at least 2");
   end

   logic [2:0]              ctl_s;
   logic                    wr_s;
   logic                    upd_s;
   logic                    clr_s;
   logic                    wr_one;
   logic                    wr_all;
   logic [ADDR_W-1:0]       wr_addr;
   logic [DATA_W-1:0]       wr_data;
   logic [N_OUT*SEL_W-1:0]  r1_sel;
   logic [N_OUT-1:0]        r1_en;

   xbr_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b111)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({clr_n, upd_n, wr_n}),
      .q     (ctl_s)
   );

   assign wr_s  = ctl_s[0];
   assign upd_s = ctl_s[1];
   assign clr_s = ctl_s[2];

   xbr_strobe_dec #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_s    (wr_s),
      .cs_n    (cs_n),
      .par_sel (par_sel),
      .sclk    (sclk),
      .addr    (addr),
      .din     (din),
      .wr_one  (wr_one),
      .wr_all  (wr_all),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   xbr_rank1 #(
      .N_OUT  (N_OUT),
      .ADDR_W (ADDR_W),
      .SEL_W  (SEL_W)
   ) u_rank1 (
      .clk     (clk),
      .wr_one  (wr_one),
      .wr_all  (wr_all),
      .wr_addr (wr_addr),
      .wr_sel  (wr_data[SEL_W-1:0]),
      .wr_en   (wr_data[SEL_W]),
      .r1_sel  (r1_sel),
      .r1_en   (r1_en)
   );

   xbr_rank2 #(
      .N_OUT        (N_OUT),
      .SEL_W        (SEL_W),
      .CLR_ZERO_SEL (CLR_ZERO_SEL)
   ) u_rank2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_s     (clr_s),
      .upd_s     (upd_s),
      .r1_sel    (r1_sel),
      .r1_en     (r1_en),
      .route_sel (route_sel),
      .route_en  (route_en)
   );

endmodule

// File: rtl/xbr_route_cfg_chk.sv
module xbr_route_cfg_chk #(
   parameter int N_OUT = 16,
   parameter int SEL_W = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   clr_s,
   input logic                   upd_s,
   input logic                   wr_one,
   input logic                   wr_all,
   input logic [N_OUT*SEL_W-1:0] r1_sel,
   input logic [N_OUT-1:0]       r1_en,
   input logic [N_OUT*SEL_W-1:0] route_sel,
   input logic [N_OUT-1:0]       route_en
);

   // R8: clear forces every driven enable off, ahead of update
   assert_clr_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_s |=> (route_en == '0));

   // R3: with update high and clear high the driving rank holds
   assert_hold_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_s && clr_s) |=> ($stable(route_en) && $stable(route_sel)));

   // R4: with update low the driving rank mirrors the staging rank one cycle later
   assert_copy_rank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_s && clr_s) |=> ((route_en == $past(r1_en)) && (route_sel == $past(r1_sel))));

   // R6: a broadcast leaves every staging enable equal
   assert_bcast_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_all |=> ((r1_en == '0) || (r1_en == '1)));

   // R2: single and broadcast write pulses never coincide
   assert_single_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_one, wr_all}));

   // R9: clear without a write leaves the staging rank untouched
   assert_clr_keeps_rank1_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_s && !wr_one && !wr_all) |=> ($stable(r1_en) && $stable(r1_sel)));

endmodule

bind xbr_route_cfg xbr_route_cfg_chk #(
   .N_OUT (N_OUT),
   .SEL_W (SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_s     (clr_s),
   .upd_s     (upd_s),
   .wr_one    (wr_one),
   .wr_all    (wr_all),
   .r1_sel    (r1_sel),
   .r1_en     (r1_en),
   .route_sel (route_sel),
   .route_en  (route_en)
);

// File: tb/test_xbr_route_cfg.sv
`timescale 1ns/1ps
module test_xbr_route_cfg;

   localparam int N = 16;
   localparam int S = 4;

   logic clk = 1'b0;
   logic rst_n, cs_n, par_sel, sclk, wr_n, upd_n, clr_n;
   logic [3:0]     addr;
   logic [4:0]     din;
   logic [N*S-1:0] route_sel;
   logic [N-1:0]   route_en;

   int n_checks = 0;
   int n_fail   = 0;

   // Reference model
   logic [S-1:0] m1_sel [N];
   logic         m1_en  [N];
   logic [S-1:0] m2_sel [N];
   logic         m2_en  [N];

   always #4 clk = ~clk;

   xbr_route_cfg i_xbr_route_cfg (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .par_sel(par_sel), .sclk(sclk),
      .wr_n(wr_n), .upd_n(upd_n), .clr_n(clr_n), .addr(addr), .din(din),
      .route_sel(route_sel), .route_en(route_en)
   );

   function automatic logic [N*S-1:0] exp_sel();
      logic [N*S-1:0] v;
      for (int i = 0; i < N; i++) v[i*S +: S] = m2_sel[i];
      return v;
   endfunction

   function automatic logic [N-1:0] exp_en();
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = m2_en[i];
      return v;
   endfunction

   // Driving-rank behaviour: clear beats update, update copies staging
   function automatic void settle();
      for (int i = 0; i < N; i++) begin
         if (!clr_n) m2_en[i] = 1'b0;
         else if (!upd_n) begin
            m2_en[i]  = m1_en[i];
            m2_sel[i] = m1_sel[i];
         end
      end
   endfunction

   task automatic check(input string tag);
      n_checks++;
      if (route_en !== exp_en() || route_sel !== exp_sel()) begin
         n_fail++;
         $display("FAIL %s: en=%h sel=%h expected en=%h sel=%h",
                  tag, route_en, route_sel, exp_en(), exp_sel());
      end
   endtask

   task automatic do_write(input logic c, input logic p, input logic k,
                           input logic [3:0] a, input logic [4:0] d, input string tag);
      @(negedge clk);
      cs_n = c; par_sel = p; sclk = k; addr = a; din = d;
      repeat (2) @(negedge clk);
      wr_n = 1'b0;
      repeat (10) @(negedge clk);
      if (!c && k) begin
         for (int i = 0; i < N; i++) begin
            if (!p || a == 4'(i)) begin
               m1_sel[i] = d[3:0];
               m1_en[i]  = d[4];
            end
         end
      end
      settle();
      check(tag);
      wr_n = 1'b1;
      repeat (4) @(negedge clk);
      cs_n = 1'b1; sclk = 1'b1; par_sel = 1'b1;
      check(tag);
   endtask

   task automatic set_upd(input logic v, input string tag);
      @(negedge clk);
      upd_n = v;
      repeat (6) @(negedge clk);
      settle();
      check(tag);
   endtask

   task automatic set_clr(input logic v, input string tag);
      @(negedge clk);
      clr_n = v;
      repeat (6) @(negedge clk);
      settle();
      check(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected finish before limit");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; par_sel = 1'b1; sclk = 1'b1;
      wr_n = 1'b1; upd_n = 1'b1; clr_n = 1'b1; addr = '0; din = '0;
      for (int i = 0; i < N; i++) begin
         m1_sel[i] = 'x; m1_en[i] = 1'bx; m2_sel[i] = '0; m2_en[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      check("R1 in reset");
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 after reset");

      // Fill staging via broadcast, outputs must not move (R3), then update (R6)
      do_write(1'b0, 1'b0, 1'b1, 4'd9, 5'h13, "R3 bcast staged");
      set_upd(1'b0, "R6 bcast applied");
      set_upd(1'b1, "R4 update released");

      // Staged single writes, then one update (R2, R3, R4)
      do_write(1'b0, 1'b1, 1'b1, 4'd2,  5'h1A, "R3 staged a2");
      do_write(1'b0, 1'b1, 1'b1, 4'd15, 5'h05, "R3 staged a15");
      do_write(1'b0, 1'b1, 1'b1, 4'd0,  5'h1F, "R3 staged a0");
      set_upd(1'b0, "R4 group applied");
      do_write(1'b0, 1'b1, 1'b1, 4'd3, 5'h0C, "R2 enable zero");

      // Transparent while update low (R5)
      do_write(1'b0, 1'b1, 1'b1, 4'd7, 5'h18, "R5 pass through");

      // Disqualified writes (R7)
      do_write(1'b1, 1'b1, 1'b1, 4'd7, 5'h11, "R7 cs high");
      do_write(1'b0, 1'b1, 1'b0, 4'd7, 5'h12, "R7 sclk low single");
      do_write(1'b0, 1'b0, 1'b0, 4'd7, 5'h13, "R7 sclk low bcast");

      // Only the falling edge writes (R10)
      @(negedge clk);
      cs_n = 1'b0; par_sel = 1'b1; sclk = 1'b1; addr = 4'd5; din = 5'h16;
      repeat (2) @(negedge clk);
      wr_n = 1'b0;
      repeat (10) @(negedge clk);
      m1_sel[5] = 4'h6; m1_en[5] = 1'b1;
      settle();
      check("R10 first edge");
      addr = 4'd6; din = 5'h1E;
      repeat (8) @(negedge clk);
      check("R10 held low");
      wr_n = 1'b1;
      repeat (8) @(negedge clk);
      check("R10 rising edge");
      cs_n = 1'b1;

      // Clear with update low: clear wins (R8), release restores (R9)
      set_clr(1'b0, "R8 clear over update");
      set_clr(1'b1, "R9 restore with update low");
      // Clear with update high, release keeps disabled, update restores
      set_upd(1'b1, "R4 update high");
      set_clr(1'b0, "R8 clear update high");
      set_clr(1'b1, "R8 stays disabled");
      set_upd(1'b0, "R9 restore after update");

      // Seeded random mix
      void'($urandom(32'h5EED_0042));
      for (int it = 0; it < 60; it++) begin
         int op;
         op = int'($urandom_range(0, 5));
         case (op)
            0, 1, 2: do_write(($urandom_range(0, 7) == 0), 1'b1,
                              ($urandom_range(0, 7) != 0),
                              4'($urandom_range(0, 15)), 5'($urandom_range(0, 31)),
                              "R2 random single");
            3: do_write(($urandom_range(0, 7) == 0), 1'b0, ($urandom_range(0, 7) != 0),
                        4'($urandom_range(0, 15)), 5'($urandom_range(0, 31)),
                        "R6 random bcast");
            4: set_upd(~upd_n, "R4 random update");
            default: begin
               set_clr(1'b0, "R8 random clear");
               set_clr(1'b1, "R9 random release");
            end
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule